// File: doc/BRIEF.md
# Serial Two-Wire Slave for Mixed-Width Word Memories

This block is a two-wire (I2C) slave port. It lets a host reach three internal targets through a 16-bit sub-address. The first target is a 256-word memory with 18-bit words. The second is a 256-word memory with 12-bit words. The third is a 16-bit control register that can only be written. The block samples SCL and SDA with a fast system clock and pulls SDA low through an open-drain enable. It talks to the two memories through simple synchronous ports:

- a write strobe for each memory;
- a shared write index and write data bus;
- a read index, whose data comes back from the memory one system clock later.

The target that a sub-address decodes to sets how many bytes make up one data word. The wide memory uses three bytes per word. The narrow memory and the control register use two. Every word is sent high byte first, and the unused upper bits are padded. Repeated words in one transaction step the sub-address by one for each word. A read issued before any sub-address has been loaded is refused at the address byte.

Top module: `i2cm_slave`

## Requirements
- R1: The 7-bit device address is binary 001111 followed by the level of `addr_sel`, and the R/W bit follows it (0 = write, 1 = read). A matching address byte is acknowledged. A mismatching one is not acknowledged, and the bytes after it are neither acknowledged nor written until the next start or stop.
- R2: A start (SDA falling while SCL is high) restarts parsing at the device address byte at any point. A stop (SDA rising while SCL is high) returns the block to idle with SDA released.
- R3: In a write, the device address is followed by the sub-address high byte, then the sub-address low byte, then data bytes. The slave acknowledges every one of these bytes.
- R4: Sub-addresses 0x0000 to 0x00FF select the wide memory at index = low byte. A word is three bytes, high byte first. The low 18 of the 24 bits are stored, and the upper 6 bits are ignored.
- R5: Sub-addresses 0x0800 to 0x08FF select the narrow memory at index = low byte. A word is two bytes, high byte first. The low 12 of the 16 bits are stored, and the upper 4 bits are ignored.
- R6: Sub-address 0x0FFF selects the control register. A write of two bytes, high byte first, loads all 16 bits onto `ctrl_q`.
- R7: Each further complete word in the same transaction goes to the next sub-address, incrementing by one, for both writes and reads.
- R8: If a read address byte arrives while no sub-address has been loaded since reset, it is not acknowledged and the slave drives no data.
- R9: In a read, the slave sends the word at the current sub-address MSB first, high byte first, with the unused upper bits as zero. It keeps sending while the master acknowledges. After a master NACK it releases SDA and drives nothing more until the next start or stop.
- R10: Reset clears `ctrl_q` to zero, releases SDA, and forgets any loaded sub-address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Selects the LSB of the device address |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| rd_idx | output | 8 | Read index toward both memories |
| wr_idx | output | 8 | Write index toward both memories |
| wr_data | output | 18 | Write data, zero-extended for the narrow memory |
| wide_we | output | 1 | One-cycle write strobe, wide memory |
| narrow_we | output | 1 | One-cycle write strobe, narrow memory |
| wide_rdata | input | 18 | Wide memory data for `rd_idx`, one clock later |
| narrow_rdata | input | 12 | Narrow memory data for `rd_idx`, one clock later |
| ctrl_q | output | 16 | Control register contents |

## Verification
The bench writes multi-word bursts to each target with junk in the unused upper bits. Reading the bursts back tells a correct byte count per word and correct masking apart from off-by-one byte assembly, and shows whether the word index advances once per word rather than once per byte. Address bytes are sent with both levels of `addr_sel`, and with the R/W bit set before any sub-address is loaded. These show whether the ACK/NACK decision follows the pin and the loaded-address state. A repeated start in the middle of a sub-address and a reset during operation check that parsing restarts cleanly and that the register clears.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEVADR,
    PH_SUBHI,
    PH_SUBLO,
    PH_WRITE,
    PH_READ,
    PH_IGNORE
  } phase_e;

  typedef enum logic [1:0] {
    TGT_WIDE,
    TGT_NARROW,
    TGT_CTRL,
    TGT_NONE
  } tgt_e;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] meta_q;
  logic [LINES-1:0] sync_q;
  logic [LINES-1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b1;
        sync_q[g] <= 1'b1;
        prev_q[g] <= 1'b1;
      end else begin
        meta_q[g] <= raw[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
  end

  assign scl_s     = sync_q[0];
  assign sda_s     = sync_q[1];
  assign scl_rise  = sync_q[0] & ~prev_q[0];
  assign scl_fall  = ~sync_q[0] & prev_q[0];
  assign start_evt = sync_q[0] & prev_q[0] & prev_q[1] & ~sync_q[1];
  assign stop_evt  = sync_q[0] & prev_q[0] & ~prev_q[1] & sync_q[1];
endmodule

// File: rtl/i2cm_decode.sv
module i2cm_decode
  import i2cm_pkg::*;
#(
  parameter int          IDX_W       = 8,
  parameter logic [15:0] WIDE_BASE   = 16'h0000,
  parameter logic [15:0] NARROW_BASE = 16'h0800,
  parameter logic [15:0] CTRL_ADDR   = 16'h0FFF
) (
  input  logic [15:0] sub_addr,
  output tgt_e        tgt,
  output logic [1:0]  last_byte
);
  localparam int HI_LSB = IDX_W;

  always_comb begin
    if (sub_addr == CTRL_ADDR) begin
      tgt = TGT_CTRL;
    end else if (sub_addr[15:HI_LSB] == WIDE_BASE[15:HI_LSB]) begin
      tgt = TGT_WIDE;
    end else if (sub_addr[15:HI_LSB] == NARROW_BASE[15:HI_LSB]) begin
      tgt = TGT_NARROW;
    end else begin
      tgt = TGT_NONE;
    end
    last_byte = (tgt == TGT_WIDE) ? 2'd2 : 2'd1;
  end
endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
  import i2cm_pkg::*;
#(
  parameter logic [5:0] DEV_PREFIX = 6'b001111,
  parameter int         IDX_W      = 8,
  parameter int         WIDE_W     = 18,
  parameter int         NARROW_W   = 12,
  parameter int         CTRL_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                addr_sel,
  output logic                sda_oe,
  output logic [IDX_W-1:0]    rd_idx,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [WIDE_W-1:0]   wr_data,
  output logic                wide_we,
  output logic                narrow_we,
  input  logic [WIDE_W-1:0]   wide_rdata,
  input  logic [NARROW_W-1:0] narrow_rdata,
  output logic [CTRL_W-1:0]   ctrl_q
);
  localparam int WORD_W = 24;
  localparam int ACC_W  = WORD_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2cm_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  phase_e             phase_q, phase_d;
  logic [3:0]         bit_q, bit_d;
  logic [7:0]         shr_q, shr_d;
  logic               slot_q, slot_d;
  logic               own_q, own_d;
  logic               oe_q, oe_d;
  logic [15:0]        sub_q, sub_d;
  logic               valid_q, valid_d;
  logic [1:0]         bidx_q, bidx_d;
  logic [ACC_W-1:0]   acc_q, acc_d;
  logic [IDX_W-1:0]   wr_idx_d;
  logic [WIDE_W-1:0]  wr_data_d;
  logic               wide_we_d, narrow_we_d;
  logic [CTRL_W-1:0]  ctrl_d;

  tgt_e       tgt;
  logic [1:0] last_b;

  i2cm_decode #(.IDX_W(IDX_W)) u_dec (
    .sub_addr(sub_q), .tgt(tgt), .last_byte(last_b)
  );

  logic [WORD_W-1:0] full_word;
  logic [WORD_W-1:0] rd_word;
  logic [1:0]        byte_sel;
  logic [7:0]        tx_byte;
  logic              dev_hit;

  assign full_word = {acc_q, shr_q};
  assign byte_sel  = last_b - bidx_q;
  assign dev_hit   = (shr_q[7:1] == {DEV_PREFIX, addr_sel});

  always_comb begin
    rd_word = '0;
    case (tgt)
      TGT_WIDE:   rd_word[WIDE_W-1:0]   = wide_rdata;
      TGT_NARROW: rd_word[NARROW_W-1:0] = narrow_rdata;
      default:    rd_word = '0;
    endcase
    case (byte_sel)
      2'd2:    tx_byte = rd_word[23:16];
      2'd1:    tx_byte = rd_word[15:8];
      default: tx_byte = rd_word[7:0];
    endcase
  end

  // next-state logic
  always_comb begin
    phase_d     = phase_q;
    bit_d       = bit_q;
    shr_d       = shr_q;
    slot_d      = slot_q;
    own_d       = own_q;
    oe_d        = oe_q;
    sub_d       = sub_q;
    valid_d     = valid_q;
    bidx_d      = bidx_q;
    acc_d       = acc_q;
    wr_idx_d    = wr_idx;
    wr_data_d   = wr_data;
    wide_we_d   = 1'b0;
    narrow_we_d = 1'b0;
    ctrl_d      = ctrl_q;
    if (start_evt) begin
      phase_d = PH_DEVADR;
      bit_d   = '0;
      slot_d  = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_evt) begin
      phase_d = PH_IDLE;
      bit_d   = '0;
      slot_d  = 1'b0;
      oe_d    = 1'b0;
    end else if (scl_rise) begin
      if (slot_q) begin
        if (!own_q && phase_q == PH_READ) begin
          if (sda_s) begin
            phase_d = PH_IGNORE;
          end else if (bidx_q == last_b) begin
            bidx_d = '0;
            sub_d  = sub_q + 16'd1;
          end else begin
            bidx_d = bidx_q + 2'd1;
          end
        end
      end else if (phase_q inside {PH_DEVADR, PH_SUBHI, PH_SUBLO, PH_WRITE}) begin
        shr_d = {shr_q[6:0], sda_s};
        bit_d = bit_q + 4'd1;
      end else if (phase_q == PH_READ) begin
        bit_d = bit_q + 4'd1;
      end
    end else if (scl_fall) begin
      if (slot_q) begin
        slot_d = 1'b0;
        bit_d  = '0;
        oe_d   = (phase_q == PH_READ) ? ~tx_byte[7] : 1'b0;
      end else if (bit_q == 4'd8) begin
        slot_d = 1'b1;
        own_d  = 1'b1;
        oe_d   = 1'b1;
        case (phase_q)
          PH_DEVADR: begin
            if (!dev_hit) begin
              phase_d = PH_IGNORE;
              oe_d    = 1'b0;
            end else if (!shr_q[0]) begin
              phase_d = PH_SUBHI;
            end else if (valid_q) begin
              phase_d = PH_READ;
              bidx_d  = '0;
            end else begin
              phase_d = PH_IGNORE;
              oe_d    = 1'b0;
            end
          end
          PH_SUBHI: begin
            sub_d[15:8] = shr_q;
            phase_d     = PH_SUBLO;
          end
          PH_SUBLO: begin
            sub_d[7:0] = shr_q;
            valid_d    = 1'b1;
            bidx_d     = '0;
            phase_d    = PH_WRITE;
          end
          PH_WRITE: begin
            if (bidx_q == last_b) begin
              bidx_d   = '0;
              sub_d    = sub_q + 16'd1;
              wr_idx_d = sub_q[IDX_W-1:0];
              case (tgt)
                TGT_WIDE: begin
                  wr_data_d = full_word[WIDE_W-1:0];
                  wide_we_d = 1'b1;
                end
                TGT_NARROW: begin
                  wr_data_d                = '0;
                  wr_data_d[NARROW_W-1:0]  = full_word[NARROW_W-1:0];
                  narrow_we_d              = 1'b1;
                end
                TGT_CTRL: ctrl_d = full_word[CTRL_W-1:0];
                default:  ctrl_d = ctrl_q;
              endcase
            end else begin
              acc_d  = {acc_q[ACC_W-9:0], shr_q};
              bidx_d = bidx_q + 2'd1;
            end
          end
          PH_READ: begin
            own_d = 1'b0;
            oe_d  = 1'b0;
          end
          default: begin
            slot_d = 1'b0;
            oe_d   = 1'b0;
          end
        endcase
      end else if (phase_q == PH_READ) begin
        oe_d = ~tx_byte[3'd7 - bit_q[2:0]];
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      bit_q     <= '0;
      shr_q     <= '0;
      slot_q    <= 1'b0;
      own_q     <= 1'b0;
      oe_q      <= 1'b0;
      sub_q     <= '0;
      valid_q   <= 1'b0;
      bidx_q    <= '0;
      acc_q     <= '0;
      wr_idx    <= '0;
      wr_data   <= '0;
      wide_we   <= 1'b0;
      narrow_we <= 1'b0;
      ctrl_q    <= '0;
    end else begin
      phase_q   <= phase_d;
      bit_q     <= bit_d;
      shr_q     <= shr_d;
      slot_q    <= slot_d;
      own_q     <= own_d;
      oe_q      <= oe_d;
      sub_q     <= sub_d;
      valid_q   <= valid_d;
      bidx_q    <= bidx_d;
      acc_q     <= acc_d;
      wr_idx    <= wr_idx_d;
      wr_data   <= wr_data_d;
      wide_we   <= wide_we_d;
      narrow_we <= narrow_we_d;
      ctrl_q    <= ctrl_d;
    end
  end

  assign sda_oe = oe_q;
  assign rd_idx = sub_q[IDX_W-1:0];
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              scl_fall,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic              wide_we,
  input logic              narrow_we,
  input logic [CTRL_W-1:0] ctrl_q
);
  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wide_we, narrow_we}));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_we || narrow_we) |=> !(wide_we || narrow_we));

  assert_ctrl_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(scl_fall));
endmodule

bind i2cm_slave i2cm_checker #(.CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_evt(start_evt), .stop_evt(stop_evt), .sda_oe(sda_oe),
  .wide_we(wide_we), .narrow_we(narrow_we), .ctrl_q(ctrl_q)
);

// File: tb/i2cm_slave_test.sv
`timescale 1ns/1ps
module i2cm_slave_test;
  localparam int Q = 20;

  logic        clk;
  logic        rst_n;
  logic        scl_m;
  logic        sda_m;
  logic        addr_sel;
  logic        sda_oe;
  logic        sda_line;
  logic [7:0]  rd_idx, wr_idx;
  logic [17:0] wr_data;
  logic        wide_we, narrow_we;
  logic [17:0] wide_rdata;
  logic [11:0] narrow_rdata;
  logic [15:0] ctrl_q;

  logic [17:0] wmem [256];
  logic [11:0] nmem [256];

  int   checks;
  int   errors;
  bit   busy;
  logic [15:0] exp_ctrl;

  assign sda_line = sda_m & ~sda_oe;

  i2cm_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .rd_idx(rd_idx), .wr_idx(wr_idx), .wr_data(wr_data),
    .wide_we(wide_we), .narrow_we(narrow_we), .wide_rdata(wide_rdata),
    .narrow_rdata(narrow_rdata), .ctrl_q(ctrl_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural memories with a one-clock read latency
  always @(posedge clk) begin
    if (wide_we)   wmem[wr_idx] <= wr_data;
    if (narrow_we) nmem[wr_idx] <= wr_data[11:0];
    wide_rdata   <= wmem[rd_idx];
    narrow_rdata <= nmem[rd_idx];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // outside transactions the line must be free and the register must match the model
  always @(negedge clk) begin
    if (rst_n && !busy) begin
      check(sda_oe == 1'b0, "R2 idle release", int'(sda_oe), 0);
      check(ctrl_q == exp_ctrl, "R6 ctrl model", int'(ctrl_q), int'(exp_ctrl));
    end
  end

  task automatic q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    q(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      q(); sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
    end
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ack = !sda_line;
    q(); scl_m = 1'b0;
  endtask

  task automatic sb(input logic [7:0] b, input bit exp_ack, input string req);
    bit ack;
    send(b, ack);
    check(ack == exp_ack, req, int'(ack), int'(exp_ack));
  endtask

  task automatic rb(input logic [7:0] exp, input bit give_ack, input string req);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); q(); scl_m = 1'b1; q();
      b[i] = sda_line;
      q(); scl_m = 1'b0;
    end
    q(); sda_m = !give_ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
    check(b == exp, req, int'(b), int'(exp));
  endtask

  task automatic end_txn();
    do_stop();
    busy = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; busy = 1'b1; exp_ctrl = 16'h0;
    scl_m = 1'b1; sda_m = 1'b1; addr_sel = 1'b0; rst_n = 1'b0;
    repeat (5) @(posedge clk); #1;
    check(sda_oe == 1'b0, "R10 reset sda", int'(sda_oe), 0);
    check(ctrl_q == 16'h0, "R10 reset ctrl", int'(ctrl_q), 0);
    rst_n = 1'b1;
    q();
    busy = 1'b0;

    // R8: read before any sub-address
    busy = 1'b1; do_start(); sb(8'h3D, 1'b0, "R8 early read nack");
    check(sda_oe == 1'b0, "R8 no drive", int'(sda_oe), 0); end_txn();

    // R4, R7, R3: wide burst with junk upper bits
    busy = 1'b1; do_start();
    sb(8'h3C, 1'b1, "R3 dev ack"); sb(8'h00, 1'b1, "R3 subhi ack"); sb(8'h10, 1'b1, "R3 sublo ack");
    sb(8'hFF, 1'b1, "R4 data ack"); sb(8'h23, 1'b1, "R4 data ack"); sb(8'h45, 1'b1, "R4 data ack");
    sb(8'h02, 1'b1, "R7 data ack"); sb(8'hAB, 1'b1, "R7 data ack"); sb(8'hCD, 1'b1, "R7 data ack");
    end_txn();
    check(wmem[8'h10] == 18'h32345, "R4 wide word", int'(wmem[8'h10]), 'h32345);
    check(wmem[8'h11] == 18'h2ABCD, "R7 wide incr", int'(wmem[8'h11]), 'h2ABCD);

    // R1: mismatching device address, nothing acknowledged or written
    busy = 1'b1; do_start();
    sb(8'h3E, 1'b0, "R1 mismatch nack"); sb(8'h00, 1'b0, "R1 ignored"); sb(8'h10, 1'b0, "R1 ignored");
    sb(8'h00, 1'b0, "R1 ignored"); sb(8'h00, 1'b0, "R1 ignored"); sb(8'h00, 1'b0, "R1 ignored");
    end_txn();
    check(wmem[8'h10] == 18'h32345, "R1 no write", int'(wmem[8'h10]), 'h32345);

    // R5: narrow burst of three words
    busy = 1'b1; do_start();
    sb(8'h3C, 1'b1, "R3 dev ack"); sb(8'h08, 1'b1, "R3 subhi ack"); sb(8'h05, 1'b1, "R3 sublo ack");
    sb(8'hF1, 1'b1, "R5 data ack"); sb(8'h23, 1'b1, "R5 data ack");
    sb(8'h0A, 1'b1, "R5 data ack"); sb(8'hBC, 1'b1, "R5 data ack");
    sb(8'h0F, 1'b1, "R5 data ack"); sb(8'hFF, 1'b1, "R5 data ack");
    end_txn();
    check(nmem[8'h05] == 12'h123, "R5 narrow word", int'(nmem[8'h05]), 'h123);
    check(nmem[8'h06] == 12'hABC, "R7 narrow incr", int'(nmem[8'h06]), 'hABC);
    check(nmem[8'h07] == 12'hFFF, "R7 narrow incr2", int'(nmem[8'h07]), 'hFFF);

    // R6: control register
    busy = 1'b1; do_start();
    sb(8'h3C, 1'b1, "R3 dev ack"); sb(8'h0F, 1'b1, "R3 subhi ack"); sb(8'hFF, 1'b1, "R3 sublo ack");
    sb(8'h5A, 1'b1, "R6 data ack"); sb(8'hC3, 1'b1, "R6 data ack");
    exp_ctrl = 16'h5AC3;
    end_txn();
    check(ctrl_q == 16'h5AC3, "R6 ctrl load", int'(ctrl_q), 'h5AC3);

    // R1: pin high selects the other address
    addr_sel = 1'b1;
    busy = 1'b1; do_start(); sb(8'h3C, 1'b0, "R1 pin high nack"); end_txn();
    busy = 1'b1; do_start();
    sb(8'h3E, 1'b1, "R1 pin high ack"); sb(8'h00, 1'b1, "R3 subhi ack"); sb(8'h20, 1'b1, "R3 sublo ack");
    sb(8'h00, 1'b1, "R4 data ack"); sb(8'h00, 1'b1, "R4 data ack"); sb(8'h01, 1'b1, "R4 data ack");
    end_txn();
    check(wmem[8'h20] == 18'h00001, "R1 pin high write", int'(wmem[8'h20]), 1);

    // R9: wide read of two words with repeated start
    busy = 1'b1; do_start();
    sb(8'h3E, 1'b1, "R9 dev ack"); sb(8'h00, 1'b1, "R9 subhi ack"); sb(8'h10, 1'b1, "R9 sublo ack");
    do_start(); sb(8'h3F, 1'b1, "R9 read ack");
    rb(8'h03, 1'b1, "R9 wide hi"); rb(8'h23, 1'b1, "R9 wide mid"); rb(8'h45, 1'b1, "R9 wide lo");
    rb(8'h02, 1'b1, "R7 read incr hi"); rb(8'hAB, 1'b1, "R7 read incr mid"); rb(8'hCD, 1'b0, "R7 read incr lo");
    q();
    check(sda_oe == 1'b0, "R9 release after nack", int'(sda_oe), 0);
    end_txn();

    // R9, R5: narrow read
    busy = 1'b1; do_start();
    sb(8'h3E, 1'b1, "R9 dev ack"); sb(8'h08, 1'b1, "R9 subhi ack"); sb(8'h06, 1'b1, "R9 sublo ack");
    do_start(); sb(8'h3F, 1'b1, "R9 read ack");
    rb(8'h0A, 1'b1, "R5 narrow hi"); rb(8'hBC, 1'b1, "R5 narrow lo");
    rb(8'h0F, 1'b1, "R7 narrow incr hi"); rb(8'hFF, 1'b0, "R7 narrow incr lo");
    end_txn();

    // R2: repeated start in the middle of a sub-address restarts parsing
    busy = 1'b1; do_start();
    sb(8'h3E, 1'b1, "R2 dev ack"); sb(8'h08, 1'b1, "R2 subhi ack");
    do_start();
    sb(8'h3E, 1'b1, "R2 restart ack"); sb(8'h0F, 1'b1, "R2 subhi ack"); sb(8'hFF, 1'b1, "R2 sublo ack");
    sb(8'h12, 1'b1, "R2 data ack"); sb(8'h34, 1'b1, "R2 data ack");
    exp_ctrl = 16'h1234;
    end_txn();
    check(ctrl_q == 16'h1234, "R2 ctrl after restart", int'(ctrl_q), 'h1234);

    // R10: reset clears the register and the loaded sub-address
    busy = 1'b1;
    rst_n = 1'b0; exp_ctrl = 16'h0;
    repeat (3) @(posedge clk); #1;
    check(ctrl_q == 16'h0, "R10 ctrl clear", int'(ctrl_q), 0);
    check(sda_oe == 1'b0, "R10 sda clear", int'(sda_oe), 0);
    rst_n = 1'b1; q();
    do_start(); sb(8'h3F, 1'b0, "R10 address forgotten"); end_txn();

    q();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule